// File: doc/BRIEF.md
# Runahead Store Forwarding Cache

While a core runs ahead of a long-latency miss, stores still leave the instruction window. They retire speculatively, and their results must never reach architectural memory. A younger runahead load may still depend on such a store after the store has left the store buffer. This block keeps those retired stores in a small direct-mapped cache so that the load can still receive the forwarded value. Each entry holds one data word together with a poison flag. The flag marks a value derived from a missing or bogus source.

The write port is driven by store pseudo-retirement. A store is recorded only when its address is known. The read port is driven by load execution, and the lookup runs alongside two external sources. The store buffer and the data cache are modelled here as hit/data inputs. A fixed priority combiner selects the load's data and its poison flag, and the result appears one cycle after the request. When runahead ends, a single strobe discards every entry.

Top module: `ra_fwd_cache`

## Requirements
- R1: After reset `ldRespValid` is 0 and every cache entry is empty, so a load that misses the store buffer and data cache reports source 0.
- R2: `ldRespValid` is 1 in the cycle after a cycle with `ldReq` high, and 0 in the cycle after a cycle with `ldReq` low.
- R3: A store with `stWrEn` and `stAddrValid` high is recorded. A later load to the same word address, with no store buffer hit, returns its data with source code 2 (cache).
- R4: A store whose `stAddrValid` is 0 writes nothing. A previously recorded entry at that address remains unchanged.
- R5: The poison flag given with a store (for example, the store that started runahead) is stored. A load served by that entry returns it on `ldRespInv`.
- R6: The cache has 16 direct-mapped word entries, indexed by address bits [3:0]. A load whose upper address bits differ from the stored tag misses. A store to that index replaces the entry.
- R7: Source priority is store buffer (code 1), then this cache (code 2), then data cache (code 3). The response carries the poison flag of the supplying source. Data cache data is always reported unpoisoned.
- R8: When no source hits, the response has source 0, data 0 and poison 1.
- R9: A cycle with `runaheadExit` high empties every entry at the clock edge. A store in that same cycle is discarded.
- R10: A store and a load to the same address in the same cycle return the store's new data and poison flag.
- R11: A load issued in the same cycle as `runaheadExit` does not hit in this cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| runaheadExit | input | 1 | Runahead has ended; empty the cache |
| stWrEn | input | 1 | Store pseudo-retires this cycle |
| stAddrValid | input | 1 | Store address is known |
| stAddr | input | ADDR_W | Store word address |
| stData | input | DATA_W | Store data |
| stInv | input | 1 | Store data is poisoned |
| ldReq | input | 1 | Load probes the sources this cycle |
| ldAddr | input | ADDR_W | Load word address |
| sbHit | input | 1 | Store buffer has a valid matching entry |
| sbData | input | DATA_W | Store buffer data |
| sbInv | input | 1 | Store buffer data is poisoned |
| dcHit | input | 1 | Data cache hit |
| dcData | input | DATA_W | Data cache data |
| ldRespValid | output | 1 | Load result valid (one cycle after request) |
| ldRespData | output | DATA_W | Load result data |
| ldRespInv | output | 1 | Load result poisoned |
| ldRespSrc | output | 2 | Supplier: 0 none, 1 store buffer, 2 cache, 3 data cache |

## Verification
Three situations are hard to reach from the ports. The first is a store and a load meeting on one address within a single cycle. The second is a flush arriving in the same cycle as both a store and a load. The third is a tag conflict on a shared index. In each case the stored content has to be observed afterwards through ordinary loads. The stimulus drives both ports together in one cycle and then probes the affected and neighbouring addresses with the external sources idle. With the external sources idle, any hit can only have come from this cache.

// File: rtl/ra_fwd_pkg.sv
package ra_fwd_pkg;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_SBUF   = 2'd1,
    SRC_RAC    = 2'd2,
    SRC_DCACHE = 2'd3
  } srcE;

  typedef struct packed {
    logic wr;      // record the store this cycle
    logic flush;   // empty every entry
    logic lookup;  // this cache may supply the load
    logic load;    // capture a load response
  } strobeT;

endpackage

// File: rtl/ra_fwd_ctrl.sv
module ra_fwd_ctrl
  import ra_fwd_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   runaheadExit,
  input  logic   stWrEn,
  input  logic   stAddrValid,
  input  logic   ldReq,
  output strobeT strb,
  output logic   respValid
);

  always_comb begin
    strb.flush  = runaheadExit;
    strb.wr     = stWrEn && stAddrValid && !runaheadExit;
    strb.load   = ldReq;
    strb.lookup = ldReq && !runaheadExit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) respValid <= 1'b0;
    else       respValid <= ldReq;
  end

  // R2: response strobe follows the request by exactly one cycle
  a_r2_resp_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    ldReq |=> respValid);
  a_r2_no_spurious_resp: assert property (@(posedge clk) disable iff (!rstN)
    !ldReq |=> !respValid);

endmodule

// File: rtl/ra_fwd_dpath.sv
module ra_fwd_dpath
  import ra_fwd_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  input  logic              stInv,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic              sbHit,
  input  logic [DATA_W-1:0] sbData,
  input  logic              sbInv,
  input  logic              dcHit,
  input  logic [DATA_W-1:0] dcData,
  output logic [DATA_W-1:0] respData,
  output logic              respInv,
  output srcE               respSrc
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [ENTRIES-1:0] validVec;
  logic [TAG_W-1:0]   tagArr  [ENTRIES];
  logic [DATA_W-1:0]  dataArr [ENTRIES];
  logic [ENTRIES-1:0] invArr;

  logic [IDX_W-1:0] wrIdx, rdIdx;
  logic [TAG_W-1:0] wrTag, rdTag;

  assign wrIdx = stAddr[IDX_W-1:0];
  assign wrTag = stAddr[ADDR_W-1:IDX_W];
  assign rdIdx = ldAddr[IDX_W-1:0];
  assign rdTag = ldAddr[ADDR_W-1:IDX_W];

  // per-entry storage
  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_entry
    logic entrySel;
    assign entrySel = strb.wr && (wrIdx == IDX_W'(gi));

    always_ff @(posedge clk) begin
      if (!rstN)           validVec[gi] <= 1'b0;
      else if (strb.flush) validVec[gi] <= 1'b0;
      else if (entrySel)   validVec[gi] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (entrySel) begin
        tagArr[gi]  <= wrTag;
        dataArr[gi] <= stData;
        invArr[gi]  <= stInv;
      end
    end
  end

  // lookup with same-cycle write bypass
  logic              cacheHit, bypassHit, racHit, racInv;
  logic [DATA_W-1:0] racData;

  always_comb begin
    cacheHit  = strb.lookup && validVec[rdIdx] && (tagArr[rdIdx] == rdTag);
    bypassHit = strb.lookup && strb.wr && (stAddr == ldAddr);
    racHit    = cacheHit || bypassHit;
    racData   = bypassHit ? stData : dataArr[rdIdx];
    racInv    = bypassHit ? stInv  : invArr[rdIdx];
  end

  // priority combiner
  logic [DATA_W-1:0] nxtData;
  logic              nxtInv;
  srcE               nxtSrc;

  always_comb begin
    if (sbHit) begin
      nxtData = sbData;  nxtInv = sbInv;  nxtSrc = SRC_SBUF;
    end else if (racHit) begin
      nxtData = racData; nxtInv = racInv; nxtSrc = SRC_RAC;
    end else if (dcHit) begin
      nxtData = dcData;  nxtInv = 1'b0;   nxtSrc = SRC_DCACHE;
    end else begin
      nxtData = '0;      nxtInv = 1'b1;   nxtSrc = SRC_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respData <= '0;
      respInv  <= 1'b1;
      respSrc  <= SRC_NONE;
    end else if (strb.load) begin
      respData <= nxtData;
      respInv  <= nxtInv;
      respSrc  <= nxtSrc;
    end
  end

  // R9: a flush leaves no entry valid
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    strb.flush |=> (validVec == '0));
  // R4: without a recorded store or flush the valid set does not move
  a_r4_no_write_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.wr && !strb.flush) |=> $stable(validVec));
  // R7: a store buffer hit always supplies the load
  a_r7_sbuf_first: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && sbHit) |=> (respSrc == SRC_SBUF));
  // R7: data cache data is reported unpoisoned
  a_r7_dcache_clean: assert property (@(posedge clk) disable iff (!rstN)
    (respSrc == SRC_DCACHE) |-> !respInv);
  // R8: no supplier means zero data, poisoned
  a_r8_none_poisoned: assert property (@(posedge clk) disable iff (!rstN)
    (respSrc == SRC_NONE) |-> (respInv && respData == '0));
  // R11: a load in a flush cycle never takes cache data
  a_r11_flush_no_hit: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load && strb.flush && !sbHit) |=> (respSrc != SRC_RAC));

endmodule

// File: rtl/ra_fwd_cache.sv
module ra_fwd_cache
  import ra_fwd_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runaheadExit,
  input  logic              stWrEn,
  input  logic              stAddrValid,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [DATA_W-1:0] stData,
  input  logic              stInv,
  input  logic              ldReq,
  input  logic [ADDR_W-1:0] ldAddr,
  input  logic              sbHit,
  input  logic [DATA_W-1:0] sbData,
  input  logic              sbInv,
  input  logic              dcHit,
  input  logic [DATA_W-1:0] dcData,
  output logic              ldRespValid,
  output logic [DATA_W-1:0] ldRespData,
  output logic              ldRespInv,
  output logic [1:0]        ldRespSrc
);

  strobeT strb;
  srcE    respSrc;

  ra_fwd_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .runaheadExit (runaheadExit),
    .stWrEn       (stWrEn),
    .stAddrValid  (stAddrValid),
    .ldReq        (ldReq),
    .strb         (strb),
    .respValid    (ldRespValid)
  );

  ra_fwd_dpath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .ENTRIES (ENTRIES)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .stAddr   (stAddr),
    .stData   (stData),
    .stInv    (stInv),
    .ldAddr   (ldAddr),
    .sbHit    (sbHit),
    .sbData   (sbData),
    .sbInv    (sbInv),
    .dcHit    (dcHit),
    .dcData   (dcData),
    .respData (ldRespData),
    .respInv  (ldRespInv),
    .respSrc  (respSrc)
  );

  assign ldRespSrc = respSrc;

endmodule

// File: tb/ra_fwd_cache_tb.sv
module ra_fwd_cache_tb;

  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN;
  logic          runaheadExit, stWrEn, stAddrValid, stInv, ldReq;
  logic          sbHit, sbInv, dcHit;
  logic [AW-1:0] stAddr, ldAddr;
  logic [DW-1:0] stData, sbData, dcData;
  logic          ldRespValid, ldRespInv;
  logic [DW-1:0] ldRespData;
  logic [1:0]    ldRespSrc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ra_fwd_cache u_dut (
    .clk(clk), .rstN(rstN), .runaheadExit(runaheadExit),
    .stWrEn(stWrEn), .stAddrValid(stAddrValid), .stAddr(stAddr),
    .stData(stData), .stInv(stInv), .ldReq(ldReq), .ldAddr(ldAddr),
    .sbHit(sbHit), .sbData(sbData), .sbInv(sbInv),
    .dcHit(dcHit), .dcData(dcData),
    .ldRespValid(ldRespValid), .ldRespData(ldRespData),
    .ldRespInv(ldRespInv), .ldRespSrc(ldRespSrc)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    runaheadExit = 0; stWrEn = 0; stAddrValid = 0; stInv = 0; ldReq = 0;
    sbHit = 0; sbInv = 0; dcHit = 0;
    stAddr = '0; ldAddr = '0; stData = '0; sbData = '0; dcData = '0;
  endtask

  task automatic expect1(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic checkResp(string req, logic [1:0] eSrc, logic [DW-1:0] eData, logic eInv);
    expect1(req, "valid", DW'(ldRespValid), 1);
    expect1(req, "src",   DW'(ldRespSrc),   DW'(eSrc));
    expect1(req, "data",  ldRespData,       eData);
    expect1(req, "inv",   DW'(ldRespInv),   DW'(eInv));
  endtask

  task automatic doStore(logic [AW-1:0] a, logic [DW-1:0] d, logic inv, logic av);
    stWrEn = 1; stAddrValid = av; stAddr = a; stData = d; stInv = inv;
    tick();
    idle();
  endtask

  task automatic doLoad(logic [AW-1:0] a, logic sh, logic [DW-1:0] sd, logic si,
                        logic dh, logic [DW-1:0] dd);
    ldReq = 1; ldAddr = a; sbHit = sh; sbData = sd; sbInv = si; dcHit = dh; dcData = dd;
    tick();
    idle();
  endtask

  task automatic t_reset();
    expect1("R1", "valid after reset", DW'(ldRespValid), 0);
    doLoad(16'h0005, 0, 0, 0, 0, 0);
    checkResp("R1", 2'd0, 0, 1);          // empty cache
    checkResp("R8", 2'd0, 0, 1);
  endtask

  task automatic t_basic();
    doStore(16'h0013, 32'hA0A0_0001, 0, 1);
    doLoad(16'h0013, 0, 0, 0, 0, 0);
    checkResp("R3", 2'd2, 32'hA0A0_0001, 0);
    tick();
    expect1("R2", "valid drops", DW'(ldRespValid), 0);
  endtask

  task automatic t_inv();
    doStore(16'h0024, 32'hB0B0_0002, 1, 1);   // runahead-triggering store
    doLoad(16'h0024, 0, 0, 0, 1, 32'h1111);
    checkResp("R5", 2'd2, 32'hB0B0_0002, 1);
  endtask

  task automatic t_noaddr();
    doStore(16'h0035, 32'hC0C0_0003, 0, 0);
    doLoad(16'h0035, 0, 0, 0, 0, 0);
    checkResp("R4", 2'd0, 0, 1);
    doStore(16'h0046, 32'hD0D0_0004, 0, 1);
    doStore(16'h0046, 32'hE0E0_0005, 1, 0);
    doLoad(16'h0046, 0, 0, 0, 0, 0);
    checkResp("R4", 2'd2, 32'hD0D0_0004, 0);
  endtask

  task automatic t_tag();
    doLoad(16'h1013, 0, 0, 0, 1, 32'hF0F0_0006);   // index 3, different tag
    checkResp("R6", 2'd3, 32'hF0F0_0006, 0);
    doStore(16'h1013, 32'h6060_0007, 0, 1);
    doLoad(16'h0013, 0, 0, 0, 0, 0);
    checkResp("R6", 2'd0, 0, 1);
    doLoad(16'h1013, 0, 0, 0, 0, 0);
    checkResp("R6", 2'd2, 32'h6060_0007, 0);
  endtask

  task automatic t_prio();
    doStore(16'h0057, 32'h8080_0008, 1, 1);
    doLoad(16'h0057, 1, 32'h9090_0009, 0, 1, 32'h7070_000A);
    checkResp("R7", 2'd1, 32'h9090_0009, 0);
    doLoad(16'h0057, 1, 32'h9090_000B, 1, 0, 0);
    checkResp("R7", 2'd1, 32'h9090_000B, 1);
    doLoad(16'h0057, 0, 0, 0, 1, 32'h7070_000A);
    checkResp("R7", 2'd2, 32'h8080_0008, 1);
    doLoad(16'h0058, 0, 0, 0, 1, 32'h7070_000C);
    checkResp("R7", 2'd3, 32'h7070_000C, 0);
  endtask

  task automatic t_bypass();
    stWrEn = 1; stAddrValid = 1; stAddr = 16'h0069; stData = 32'h4242_000D; stInv = 0;
    ldReq = 1; ldAddr = 16'h0069; dcHit = 1; dcData = 32'h1234;
    tick();
    idle();
    checkResp("R10", 2'd2, 32'h4242_000D, 0);
    stWrEn = 1; stAddrValid = 1; stAddr = 16'h0069; stData = 32'h4343_000E; stInv = 1;
    ldReq = 1; ldAddr = 16'h0069;
    tick();
    idle();
    checkResp("R10", 2'd2, 32'h4343_000E, 1);
    doLoad(16'h0069, 0, 0, 0, 0, 0);
    checkResp("R10", 2'd2, 32'h4343_000E, 1);
  endtask

  task automatic t_flush();
    doStore(16'h007A, 32'h5151_000F, 0, 1);
    runaheadExit = 1;
    stWrEn = 1; stAddrValid = 1; stAddr = 16'h008B; stData = 32'h5252_0010;
    ldReq = 1; ldAddr = 16'h007A;
    tick();
    idle();
    checkResp("R11", 2'd0, 0, 1);
    doLoad(16'h007A, 0, 0, 0, 0, 0);
    checkResp("R9", 2'd0, 0, 1);
    doLoad(16'h008B, 0, 0, 0, 0, 0);
    checkResp("R9", 2'd0, 0, 1);
    doLoad(16'h0013, 0, 0, 0, 0, 0);
    checkResp("R9", 2'd0, 0, 1);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    idle();
    rstN = 0;
    repeat (3) tick();
    rstN = 1;
    t_reset();
    t_basic();
    t_inv();
    t_noaddr();
    t_tag();
    t_prio();
    t_bypass();
    t_flush();
    finishRun();
  end

endmodule